// File: doc/BRIEF.md
# Multicycle CPU Hardwired Control Sequencer

This block is the finite-state controller of a small multicycle processor. The processor uses 16-bit instructions and a 12-bit memory address. Every instruction is fetched as two bytes, low byte first. A decode cycle follows, which also latches the two register-file read ports into operand buffers. The controller then steps through a short sequence chosen by the instruction's class: register arithmetic, memory access or branch, load-immediate, jump-and-link or transfer, and no-op or halt.

Each state drives a fixed set of datapath strobes and mux selects. The controller reads only two things: the opcode field of the instruction register (bits 15..12, as `op_i`) and the ALU equality flag. The state register and every datapath register update on the same rising edge, so a strobe raised in a state takes effect at the end of that state.

Top module: `mc_ctrl`

## Requirements
- R1: After reset the controller is in the first fetch cycle. In that cycle mem_rd_o, pc_inc_o and ir_lo_ld_o are 1, addr_sel_o is 0 (PC), and rf_we_o and mem_wr_o are 0.
- R2: The first fetch cycle is always followed by the second fetch cycle, which has mem_rd_o, pc_inc_o and ir_hi_ld_o at 1 and addr_sel_o at 0. The decode cycle comes next and asserts ab_ld_o.
- R3: Opcodes 1 to 4 (add, subtract, and, or) run two cycles after decode. The first asserts aluout_ld_o with alu_op_o of 0, 1, 2 or 3 respectively. The second asserts rf_we_o with rf_src_o=0 (ALUout) and rf_dst_o=0 (Rc). Fetch to fetch takes 5 cycles.
- R4: Opcode 5 (load) runs three cycles after decode. The first is address: aluout_ld_o, alu_b_sel_o=1 (offset), alu_op_o=0. The second is memory read: addr_sel_o=1 (ALUout), mem_rd_o, mdr_ld_o. The third writes back: rf_we_o with rf_src_o=1 (MDR). Fetch to fetch takes 6 cycles.
- R5: Opcode 6 (store) runs the same address cycle, then one cycle with mem_wr_o=1 and addr_sel_o=1. It never asserts rf_we_o. Fetch to fetch takes 5 cycles.
- R6: Opcode 7 (branch if equal) compares in one cycle with alu_op_o=1 and samples eq_i there. If equal, it runs a target cycle (aluout_ld_o, alu_a_sel_o=1 for PC, alu_b_sel_o=1), then a cycle with pc_ld_o=1 and pc_src_o=0 (ALUout): 6 cycles in all. If not equal, it returns to fetch after the compare without pc_ld_o: 4 cycles.
- R7: Opcode 8 (load immediate) takes one cycle after decode, with rf_we_o, rf_src_o=2 (IR low byte) and rf_dst_o=0. Fetch to fetch takes 4 cycles.
- R8: Opcode 9 (jump and link) takes one cycle after decode. In it rf_we_o=1, rf_src_o=3 (PC), rf_dst_o=1 (Ra), pc_ld_o=1 and pc_src_o=1 (B buffer, holding Rc) all change on the same edge.
- R9: Opcode 10 (transfer) takes two cycles after decode. The first has aluout_ld_o with alu_op_o=4 (pass A). The second has rf_we_o with rf_src_o=0 and rf_dst_o=0. Fetch to fetch takes 5 cycles.
- R10: Opcode 15 (halt) enters a state that asserts no strobe and is left only by reset. Reset then returns to the first fetch cycle.
- R11: Opcode 0 (no-op) and the undefined opcodes 11 to 14 return to fetch straight after decode: 3 cycles with no register, memory or PC write.
- R12: pc_inc_o and pc_ld_o are never 1 together, rf_we_o and mem_wr_o are never 1 together, and mem_wr_o or mdr_ld_o always comes with addr_sel_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode field of the instruction register |
| eq_i | input | 1 | ALU equality flag |
| pc_inc_o | output | 1 | Increment PC |
| pc_ld_o | output | 1 | Load PC |
| pc_src_o | output | 1 | PC load source: 0 ALUout, 1 B buffer |
| ir_lo_ld_o | output | 1 | Load IR bits 7..0 from memory |
| ir_hi_ld_o | output | 1 | Load IR bits 15..8 from memory |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUout low 12 bits |
| alu_a_sel_o | output | 1 | ALU input A: 0 A buffer, 1 PC |
| alu_b_sel_o | output | 1 | ALU input B: 0 B buffer, 1 offset |
| alu_op_o | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 pass A |
| ab_ld_o | output | 1 | Load A/B operand buffers |
| aluout_ld_o | output | 1 | Load ALUout buffer |
| mdr_ld_o | output | 1 | Load MDR from memory |
| rf_we_o | output | 1 | Register file write |
| rf_src_o | output | 2 | Write data: 0 ALUout, 1 MDR, 2 IR low byte, 3 PC |
| rf_dst_o | output | 1 | Write target: 0 Rc, 1 Ra |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |

## Verification
The bench runs every opcode class through a complete fetch-to-fetch round trip. For each round trip it counts the cycles and the register, memory and PC writes. A decoder that routed one class into another's sequence would show a different cycle count or a missing or extra write. The branch is run with the equality flag both set and clear: a controller that ignored the flag would load the PC on a mismatch. Undefined opcodes are checked to leave no write behind. The halt state is held for many cycles to catch a leak back into fetch, and then reset is checked to pull the controller out of it. The jump-and-link cycle is checked strobe by strobe: a version that split its two writes over two cycles would show neither write, or only one, in the single cycle the requirement allows.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W  = 4;
  localparam int ALU_W = 3;
  localparam int SRC_W = 2;

  typedef enum logic [4:0] {
    ST_F1, ST_F2, ST_DEC,
    ST_R_EXE, ST_R_WB,
    ST_M_ADDR, ST_LD_MEM, ST_LD_WB, ST_ST_MEM,
    ST_BQ_CMP, ST_BQ_TGT, ST_BQ_PC,
    ST_LI_WB, ST_JL, ST_XF_ALU, ST_XF_WB,
    ST_HALT
  } state_e;

  localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OP_W-1:0] OP_OR   = 4'd4;
  localparam logic [OP_W-1:0] OP_LD   = 4'd5;
  localparam logic [OP_W-1:0] OP_ST   = 4'd6;
  localparam logic [OP_W-1:0] OP_BEQ  = 4'd7;
  localparam logic [OP_W-1:0] OP_LDI  = 4'd8;
  localparam logic [OP_W-1:0] OP_JAL  = 4'd9;
  localparam logic [OP_W-1:0] OP_XFR  = 4'd10;
  localparam logic [OP_W-1:0] OP_HALT = 4'd15;

  localparam logic [ALU_W-1:0] ALU_ADD  = 3'd0;
  localparam logic [ALU_W-1:0] ALU_SUB  = 3'd1;
  localparam logic [ALU_W-1:0] ALU_PASS = 3'd4;

  localparam logic [SRC_W-1:0] RF_ALUOUT = 2'd0;
  localparam logic [SRC_W-1:0] RF_MDR    = 2'd1;
  localparam logic [SRC_W-1:0] RF_IMM    = 2'd2;
  localparam logic [SRC_W-1:0] RF_PC     = 2'd3;

  typedef struct packed {
    logic             pc_inc;
    logic             pc_ld;
    logic             pc_src;
    logic             ir_lo_ld;
    logic             ir_hi_ld;
    logic             addr_sel;
    logic             alu_a_sel;
    logic             alu_b_sel;
    logic [ALU_W-1:0] alu_op;
    logic             ab_ld;
    logic             aluout_ld;
    logic             mdr_ld;
    logic             rf_we;
    logic [SRC_W-1:0] rf_src;
    logic             rf_dst;
    logic             mem_rd;
    logic             mem_wr;
  } ctl_t;
endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  state_e          state_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            eq_i,
  output state_e          next_o
);
  always_comb begin
    next_o = ST_F1;
    unique case (state_i)
      ST_F1:     next_o = ST_F2;
      ST_F2:     next_o = ST_DEC;
      ST_DEC: begin
        if (op_i >= OP_ADD && op_i <= OP_OR) next_o = ST_R_EXE;
        else begin
          case (op_i)
            OP_LD, OP_ST: next_o = ST_M_ADDR;
            OP_BEQ:       next_o = ST_BQ_CMP;
            OP_LDI:       next_o = ST_LI_WB;
            OP_JAL:       next_o = ST_JL;
            OP_XFR:       next_o = ST_XF_ALU;
            OP_HALT:      next_o = ST_HALT;
            default:      next_o = ST_F1; // NOP and undefined codes
          endcase
        end
      end
      ST_R_EXE:  next_o = ST_R_WB;
      ST_M_ADDR: next_o = (op_i == OP_ST) ? ST_ST_MEM : ST_LD_MEM;
      ST_LD_MEM: next_o = ST_LD_WB;
      ST_BQ_CMP: next_o = eq_i ? ST_BQ_TGT : ST_F1;
      ST_BQ_TGT: next_o = ST_BQ_PC;
      ST_XF_ALU: next_o = ST_XF_WB;
      ST_HALT:   next_o = ST_HALT;
      default:   next_o = ST_F1;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e          state_i,
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  logic [OP_W-1:0] r_idx;
  assign r_idx = op_i - OP_ADD;

  always_comb begin
    ctl_o = '0;
    unique case (state_i)
      ST_F1: begin
        ctl_o.mem_rd = 1'b1; ctl_o.pc_inc = 1'b1; ctl_o.ir_lo_ld = 1'b1;
      end
      ST_F2: begin
        ctl_o.mem_rd = 1'b1; ctl_o.pc_inc = 1'b1; ctl_o.ir_hi_ld = 1'b1;
      end
      ST_DEC:    ctl_o.ab_ld = 1'b1;
      ST_R_EXE: begin
        ctl_o.aluout_ld = 1'b1;
        ctl_o.alu_op    = r_idx[ALU_W-1:0];
      end
      ST_R_WB, ST_XF_WB: begin
        ctl_o.rf_we = 1'b1; ctl_o.rf_src = RF_ALUOUT;
      end
      ST_M_ADDR: begin
        ctl_o.alu_b_sel = 1'b1; ctl_o.aluout_ld = 1'b1; ctl_o.alu_op = ALU_ADD;
      end
      ST_LD_MEM: begin
        ctl_o.addr_sel = 1'b1; ctl_o.mem_rd = 1'b1; ctl_o.mdr_ld = 1'b1;
      end
      ST_LD_WB: begin
        ctl_o.rf_we = 1'b1; ctl_o.rf_src = RF_MDR;
      end
      ST_ST_MEM: begin
        ctl_o.addr_sel = 1'b1; ctl_o.mem_wr = 1'b1;
      end
      ST_BQ_CMP: ctl_o.alu_op = ALU_SUB;
      ST_BQ_TGT: begin
        ctl_o.alu_a_sel = 1'b1; ctl_o.alu_b_sel = 1'b1;
        ctl_o.aluout_ld = 1'b1; ctl_o.alu_op = ALU_ADD;
      end
      ST_BQ_PC:  ctl_o.pc_ld = 1'b1;
      ST_LI_WB: begin
        ctl_o.rf_we = 1'b1; ctl_o.rf_src = RF_IMM;
      end
      ST_JL: begin
        // link and jump share one edge: old PC to Ra, B buffer to PC
        ctl_o.rf_we = 1'b1; ctl_o.rf_src = RF_PC; ctl_o.rf_dst = 1'b1;
        ctl_o.pc_ld = 1'b1; ctl_o.pc_src = 1'b1;
      end
      ST_XF_ALU: begin
        ctl_o.aluout_ld = 1'b1; ctl_o.alu_op = ALU_PASS;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic             eq_i,
  output logic             pc_inc_o,
  output logic             pc_ld_o,
  output logic             pc_src_o,
  output logic             ir_lo_ld_o,
  output logic             ir_hi_ld_o,
  output logic             addr_sel_o,
  output logic             alu_a_sel_o,
  output logic             alu_b_sel_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             ab_ld_o,
  output logic             aluout_ld_o,
  output logic             mdr_ld_o,
  output logic             rf_we_o,
  output logic [SRC_W-1:0] rf_src_o,
  output logic             rf_dst_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o
);
  state_e state_q, state_d;
  ctl_t   ctl;

  mc_ctrl_next u_next (.state_i(state_q), .op_i(op_i), .eq_i(eq_i), .next_o(state_d));
  mc_ctrl_out  u_out  (.state_i(state_q), .op_i(op_i), .ctl_o(ctl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F1;
    else         state_q <= state_d;
  end

  assign pc_inc_o    = ctl.pc_inc;
  assign pc_ld_o     = ctl.pc_ld;
  assign pc_src_o    = ctl.pc_src;
  assign ir_lo_ld_o  = ctl.ir_lo_ld;
  assign ir_hi_ld_o  = ctl.ir_hi_ld;
  assign addr_sel_o  = ctl.addr_sel;
  assign alu_a_sel_o = ctl.alu_a_sel;
  assign alu_b_sel_o = ctl.alu_b_sel;
  assign alu_op_o    = ctl.alu_op;
  assign ab_ld_o     = ctl.ab_ld;
  assign aluout_ld_o = ctl.aluout_ld;
  assign mdr_ld_o    = ctl.mdr_ld;
  assign rf_we_o     = ctl.rf_we;
  assign rf_src_o    = ctl.rf_src;
  assign rf_dst_o    = ctl.rf_dst;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_wr_o    = ctl.mem_wr;

  assert_f1_then_f2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_lo_ld_o |=> ir_hi_ld_o);
  assert_f2_then_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_hi_ld_o |=> ab_ld_o);
  assert_r_writeback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_R_EXE) |=> (rf_we_o && rf_src_o == RF_ALUOUT));
  assert_load_writeback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdr_ld_o |=> (rf_we_o && rf_src_o == RF_MDR));
  assert_beq_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BQ_CMP && !eq_i) |=> (ir_lo_ld_o && !pc_ld_o));
  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> (state_q == ST_HALT));
  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |-> !(pc_inc_o || pc_ld_o || rf_we_o || mem_rd_o || mem_wr_o));
  assert_pc_conflict_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_inc_o && pc_ld_o));
  assert_one_writer_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && mem_wr_o));
  assert_data_addr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || mdr_ld_o) |-> addr_sel_o);
endmodule

// File: tb/mc_ctrl_test.sv
module mc_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] op = 4'd0;
  logic eq = 1'b0;
  logic pc_inc, pc_ld, pc_src, ir_lo, ir_hi, addr_sel, a_sel, b_sel;
  logic [2:0] alu_op;
  logic ab_ld, aluout_ld, mdr_ld, rf_we, rf_dst, mem_rd, mem_wr;
  logic [1:0] rf_src;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  mc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .eq_i(eq),
    .pc_inc_o(pc_inc), .pc_ld_o(pc_ld), .pc_src_o(pc_src),
    .ir_lo_ld_o(ir_lo), .ir_hi_ld_o(ir_hi), .addr_sel_o(addr_sel),
    .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .alu_op_o(alu_op),
    .ab_ld_o(ab_ld), .aluout_ld_o(aluout_ld), .mdr_ld_o(mdr_ld),
    .rf_we_o(rf_we), .rf_src_o(rf_src), .rf_dst_o(rf_dst),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr)
  );

  // {op, eq, cycles, rf writes, mem reads, mem writes, pc loads}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {4'd0,  1'b0, 4'd3, 2'd0, 2'd2, 2'd0, 2'd0},  // R11 nop
    {4'd1,  1'b0, 4'd5, 2'd1, 2'd2, 2'd0, 2'd0},  // R3 add
    {4'd2,  1'b0, 4'd5, 2'd1, 2'd2, 2'd0, 2'd0},  // R3 sub
    {4'd3,  1'b0, 4'd5, 2'd1, 2'd2, 2'd0, 2'd0},  // R3 and
    {4'd4,  1'b0, 4'd5, 2'd1, 2'd2, 2'd0, 2'd0},  // R3 or
    {4'd5,  1'b0, 4'd6, 2'd1, 2'd3, 2'd0, 2'd0},  // R4 load
    {4'd6,  1'b0, 4'd5, 2'd0, 2'd2, 2'd1, 2'd0},  // R5 store
    {4'd7,  1'b1, 4'd6, 2'd0, 2'd2, 2'd0, 2'd1},  // R6 taken
    {4'd7,  1'b0, 4'd4, 2'd0, 2'd2, 2'd0, 2'd0},  // R6 not taken
    {4'd8,  1'b0, 4'd4, 2'd1, 2'd2, 2'd0, 2'd0},  // R7 ldi
    {4'd9,  1'b0, 4'd4, 2'd1, 2'd2, 2'd0, 2'd1},  // R8 jal
    {4'd10, 1'b0, 4'd5, 2'd1, 2'd2, 2'd0, 2'd0},  // R9 xfer
    {4'd11, 1'b0, 4'd3, 2'd0, 2'd2, 2'd0, 2'd0},  // R11 undefined
    {4'd14, 1'b0, 4'd3, 2'd0, 2'd2, 2'd0, 2'd0}   // R11 undefined
  };

  function automatic string req_of(input logic [3:0] o);
    if (o >= 4'd1 && o <= 4'd4) return "R3";
    case (o)
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic busy();
    return pc_inc | pc_ld | ir_lo | ir_hi | ab_ld | aluout_ld | mdr_ld | rf_we | mem_rd | mem_wr;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ir_lo_ld", int'(ir_lo), 1);
    chk("R1 pc_inc", int'(pc_inc), 1);
    chk("R1 mem_rd", int'(mem_rd), 1);
    chk("R1 addr_sel", int'(addr_sel), 0);
    chk("R1 writes", int'(rf_we | mem_wr), 0);

    for (int v = 0; v < NV; v++) begin
      int cyc, nwe, nrd, nwr, npl;
      op = VEC[v][16:13];
      eq = VEC[v][12];
      cyc = 0; nwe = 0; nrd = 0; nwr = 0; npl = 0;
      do begin
        nwe += int'(rf_we); nrd += int'(mem_rd);
        nwr += int'(mem_wr); npl += int'(pc_ld);
        cyc++;
        step();
      end while (!ir_lo && cyc < 40);
      chk({req_of(op), " cycles"}, cyc, int'(VEC[v][11:8]));
      chk({req_of(op), " rf writes"}, nwe, int'(VEC[v][7:6]));
      chk({req_of(op), " mem reads"}, nrd, int'(VEC[v][5:4]));
      chk({req_of(op), " mem writes"}, nwr, int'(VEC[v][3:2]));
      chk({req_of(op), " pc loads"}, npl, int'(VEC[v][1:0]));
    end

    // R2 / R3 detail, subtract
    op = 4'd2; eq = 1'b0;
    step();
    chk("R2 f2 ir_hi", int'(ir_hi && pc_inc && mem_rd), 1);
    chk("R2 f2 addr", int'(addr_sel), 0);
    step();
    chk("R2 dec ab_ld", int'(ab_ld), 1);
    step();
    chk("R3 exe aluout_ld", int'(aluout_ld), 1);
    chk("R3 exe alu_op", int'(alu_op), 1);
    step();
    chk("R3 wb", int'({rf_we, rf_src, rf_dst}), 4'b1000);
    step();

    // R4 detail
    op = 4'd5;
    repeat (3) step();
    chk("R4 addr", int'({aluout_ld, b_sel, alu_op}), 5'b11000);
    step();
    chk("R4 mem", int'({addr_sel, mem_rd, mdr_ld}), 3'b111);
    step();
    chk("R4 wb", int'({rf_we, rf_src}), 3'b101);
    step();

    // R6 taken detail
    op = 4'd7; eq = 1'b1;
    repeat (3) step();
    chk("R6 cmp alu_op", int'(alu_op), 1);
    step(); eq = 1'b0;
    chk("R6 target", int'({aluout_ld, a_sel, b_sel}), 3'b111);
    step();
    chk("R6 pc", int'({pc_ld, pc_src, pc_inc}), 3'b100);
    step();

    // R7 detail
    op = 4'd8;
    repeat (3) step();
    chk("R7 ldi", int'({rf_we, rf_src, rf_dst}), 4'b1100);
    step();

    // R8 detail
    op = 4'd9;
    repeat (3) step();
    chk("R8 link", int'({rf_we, rf_src, rf_dst}), 4'b1111);
    chk("R8 jump", int'({pc_ld, pc_src, pc_inc}), 3'b110);
    step();
    chk("R8 back to fetch", int'(ir_lo), 1);

    // R9 detail
    op = 4'd10;
    repeat (3) step();
    chk("R9 pass", int'({aluout_ld, alu_op}), 4'b1100);
    step();
    chk("R9 wb", int'({rf_we, rf_src, rf_dst}), 4'b1000);
    step();

    // R10 halt
    op = 4'd15;
    repeat (3) step();
    begin
      int act = 0;
      for (int i = 0; i < 30; i++) begin
        act += int'(busy());
        step();
      end
      chk("R10 halt quiet", act, 0);
    end
    op = 4'd0;
    @(negedge clk); rst_ni = 1'b0;
    #1;
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk("R10 reset exits halt", int'(ir_lo && pc_inc && !rf_we && !mem_wr), 1);
    step();
    chk("R10 fetch resumes", int'(ir_hi), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule